// File: doc/BRIEF.md
# GF(2^m) Shared-Engine Field Multiplier and Divider

This block computes either a field quotient `a / b mod g` or a field product `a * b mod g` over GF(2^m) in polynomial basis. One bit-serial engine serves both operations. Each iteration conditionally adds and swaps a small set of polynomial registers, then shifts right by one bit, reducing modulo a working polynomial. Multiplication runs on the same right-shifting datapath. It feeds the engine bit-reversed operands and the reciprocal of `g`, and reverses the product on the way out. The mode input only changes how the registers are loaded.

An operation enters through a valid/ready command port. `op_ready` is high only while the engine is idle. A command is taken on a clock edge where `op_valid` and `op_ready` are both high. The result leaves through a valid/ready port. `res_valid` stays high and `res_data` stays constant until a clock edge where `res_ready` is high. The engine takes no new command until the previous result has been accepted, so back-pressure on the result port stalls the command port. `busy` is high while iterations are running. The field size `M` and the irreducible polynomial `G` (M+1 bits, bit M and bit 0 set) are parameters. A divisor of zero is not detected and gives an unspecified result.

Top module: `gfmd_unit`

## Requirements
- R1: With `op_div` = 1, the accepted command yields `res_data` = `op_a` * `op_b`^-1 mod `G` for any nonzero `op_b`.
- R2: With `op_div` = 0, the accepted command yields `res_data` = `op_a` * `op_b` mod `G`.
- R3: A division raises `res_valid` exactly 2M-1 clock cycles after the edge that accepted it.
- R4: A multiplication raises `res_valid` exactly M clock cycles after the edge that accepted it.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` holds its value and `op_ready` stays low. The edge with `res_ready` high clears `res_valid` and makes `op_ready` high again.
- R6: `op_valid` asserted while the engine is busy is ignored. It produces no extra result, it does not change the running result, and `busy` stays high.
- R7: During and right after reset, `op_ready` = 1, `res_valid` = 0 and `busy` = 0.
- R8: During a multiplication the swap partner register stays zero, the addend register never changes and no swap occurs (the step counter never goes negative).
- R9: With M = 4 and G = 10011 (binary), a = 1101 and b = 0111 give a quotient of 1000 after 7 cycles and a product of 0101 after 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command valid |
| op_ready | output | 1 | Engine idle and able to take a command |
| op_div | input | 1 | 1 = division a/b, 0 = multiplication a*b |
| op_a | input | M | Dividend or first factor |
| op_b | input | M | Divisor or second factor |
| res_valid | output | 1 | Result valid, held until accepted |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | M | Field result, meaningful only while res_valid is high |
| busy | output | 1 | Iterations in progress |

## Verification
A quotient is due 2M-1 cycles after its accepting edge and a product M cycles after it. The driver records the cycle number of the accepting edge with each expected item. The monitor samples on the falling edge and subtracts that number from the cycle in which it first sees `res_valid`, so every result is checked for both value and arrival cycle. The consumer holds `res_ready` low for a varying number of cycles, and the data is rechecked on every stalled cycle. A bound checker counts the cycles of each run independently, which tests the same latency windows without any long delay in a property.

// File: rtl/gfmd_pkg.sv
package gfmd_pkg;
  // Sequencer phases of the shared engine
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } gfmd_state_e;
endpackage

// File: rtl/gfmd_init.sv
// Operand loading: selects the starting register image for the chosen mode.
module gfmd_init #(
  parameter int         M = 8,
  parameter logic [M:0] G = 9'h11B
) (
  input  logic                            div_i,
  input  logic [M-1:0]                    a_i,
  input  logic [M-1:0]                    b_i,
  output logic [M:0]                      r_o,
  output logic [M:0]                      s_o,
  output logic [M:0]                      u_o,
  output logic [M:0]                      v_o,
  output logic [M:0]                      p_o,
  output logic [$clog2(M+1):0]            d_o
);
  localparam int W  = M + 1;
  localparam int DW = $clog2(M+1) + 1;

  logic [M-1:0] a_rev, b_rev;
  logic [W-1:0] g_rev;

  // Reciprocal forms: bit order mirrored
  for (genvar i = 0; i < M; i++) begin : g_opnd_rev
    assign a_rev[i] = a_i[M-1-i];
    assign b_rev[i] = b_i[M-1-i];
  end
  for (genvar i = 0; i < W; i++) begin : g_poly_rev
    assign g_rev[i] = G[W-1-i];
  end

  always_comb begin
    if (div_i) begin
      r_o = {1'b0, b_i};
      s_o = G;
      u_o = {1'b0, a_i};
      v_o = '0;
      p_o = G;
      d_o = '1;                 // -1 in two's complement
    end else begin
      r_o = {1'b0, b_rev};
      s_o = '0;
      u_o = '0;
      v_o = {a_rev, 1'b0};      // reversed factor times x
      p_o = g_rev;
      d_o = DW'(M);
    end
  end
endmodule

// File: rtl/gfmd_step.sv
// One iteration of the right-shifting binary extended-gcd update.
module gfmd_step #(
  parameter int M = 8
) (
  input  logic [M:0]             r_i,
  input  logic [M:0]             s_i,
  input  logic [M:0]             u_i,
  input  logic [M:0]             v_i,
  input  logic [M:0]             p_i,
  input  logic [$clog2(M+1):0]   d_i,
  output logic [M:0]             r_o,
  output logic [M:0]             s_o,
  output logic [M:0]             u_o,
  output logic [M:0]             v_o,
  output logic [$clog2(M+1):0]   d_o
);
  localparam int W  = M + 1;
  localparam int DW = $clog2(M+1) + 1;

  logic         lsb, swap, fold;
  logic [W-1:0] r_sum, u_sum, u_red;

  assign lsb   = r_i[0];
  assign swap  = lsb & d_i[DW-1];
  assign r_sum = r_i ^ ({W{lsb}} & s_i);
  assign u_sum = u_i ^ ({W{lsb}} & v_i);
  // Make the sum even by adding p when its low bit is set, then divide by x
  assign fold  = u_sum[0];
  assign u_red = u_sum ^ ({W{fold}} & p_i);

  assign r_o = r_sum >> 1;
  assign u_o = u_red >> 1;
  assign s_o = swap ? r_i : s_i;
  assign v_o = swap ? u_i : v_i;
  assign d_o = swap ? ~d_i : d_i - DW'(1);
endmodule

// File: rtl/gfmd_ctrl.sv
// Sequencer: command acceptance, iteration count, result hold.
module gfmd_ctrl
  import gfmd_pkg::*;
#(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic div_i,
  input  logic res_ready,
  output logic op_ready,
  output logic load,
  output logic run,
  output logic res_valid
);
  localparam int              CW       = $clog2(2*M);
  localparam logic [CW-1:0]   DIV_LAST = CW'(2*M-2);
  localparam logic [CW-1:0]   MUL_LAST = CW'(M-1);

  gfmd_state_e   state_q;
  logic [CW-1:0] cnt_q;

  assign op_ready  = (state_q == ST_IDLE);
  assign load      = op_ready & op_valid;
  assign run       = (state_q == ST_RUN);
  assign res_valid = (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (op_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= div_i ? DIV_LAST : MUL_LAST;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_HOLD;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        ST_HOLD: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfmd_unit.sv
// Combined GF(2^m) divider / multiplier on one shared serial engine.
module gfmd_unit #(
  parameter int         M = 8,
  parameter logic [M:0] G = 9'h11B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic         op_div,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [M-1:0] res_data,
  output logic         busy
);
  localparam int W  = M + 1;
  localparam int DW = $clog2(M+1) + 1;

  logic          load, run, mode_q;
  logic [W-1:0]  r_q, s_q, u_q, v_q, p_q;
  logic [DW-1:0] d_q;
  logic [W-1:0]  r_i, s_i, u_i, v_i, p_i;
  logic [DW-1:0] d_i;
  logic [W-1:0]  r_n, s_n, u_n, v_n;
  logic [DW-1:0] d_n;
  logic [M-1:0]  prod;

  gfmd_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .div_i(op_div),
    .res_ready(res_ready), .op_ready(op_ready), .load(load), .run(run),
    .res_valid(res_valid)
  );

  gfmd_init #(.M(M), .G(G)) u_init (
    .div_i(op_div), .a_i(op_a), .b_i(op_b),
    .r_o(r_i), .s_o(s_i), .u_o(u_i), .v_o(v_i), .p_o(p_i), .d_o(d_i)
  );

  gfmd_step #(.M(M)) u_step (
    .r_i(r_q), .s_i(s_q), .u_i(u_q), .v_i(v_q), .p_i(p_q), .d_i(d_q),
    .r_o(r_n), .s_o(s_n), .u_o(u_n), .v_o(v_n), .d_o(d_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {r_q, s_q, u_q, v_q, p_q} <= '0;
      d_q    <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      r_q <= r_i; s_q <= s_i; u_q <= u_i; v_q <= v_i; p_q <= p_i;
      d_q    <= d_i;
      mode_q <= op_div;
    end else if (run) begin
      r_q <= r_n; s_q <= s_n; u_q <= u_n; v_q <= v_n;
      d_q <= d_n;
    end
  end

  // Product emerges reversed in u; quotient sits in v
  for (genvar i = 0; i < M; i++) begin : g_out_rev
    assign prod[i] = u_q[M-1-i];
  end

  assign res_data = mode_q ? v_q[M-1:0] : prod;
  assign busy     = run;
endmodule

// File: rtl/gfmd_unit_chk.sv
module gfmd_unit_chk #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic         op_div,
  input logic         res_valid,
  input logic         res_ready,
  input logic [M-1:0] res_data,
  input logic         busy,
  input logic         mode_q,
  input logic [M:0]   s_q,
  input logic [M:0]   v_q,
  input logic         d_sign
);
  localparam int LW = $clog2(2*M) + 1;

  logic [LW-1:0] lat_q;
  logic          div_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      div_c <= 1'b0;
    end else if (op_valid && op_ready) begin
      lat_q <= '0;
      div_c <= op_div;
    end else if (busy) begin
      lat_q <= lat_q + LW'(1);
    end
  end

  // R3
  lat_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && div_c |-> lat_q == LW'(2*M-1));
  // R4
  lat_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && !div_c |-> lat_q == LW'(M));
  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || res_valid) |-> !op_ready);
  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> busy);
  // R8
  mul_szero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_q |-> s_q == '0);
  // R8
  mul_vfixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_q && $past(busy) |-> $stable(v_q));
  // R8
  mul_noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_q |-> !d_sign);
endmodule

bind gfmd_unit gfmd_unit_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_div(op_div), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .busy(busy), .mode_q(mode_q), .s_q(s_q),
  .v_q(v_q), .d_sign(d_q[$clog2(M+1)])
);

// File: tb/gfmd_unit_test.sv
`timescale 1ns/1ps
module gfmd_unit_test;
  localparam int         M  = 8;
  localparam logic [M:0] G  = 9'h11B;
  localparam int         MS = 4;
  localparam logic [MS:0] GS = 5'b10011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid, op_ready, op_div, res_valid, res_ready, busy;
  logic [M-1:0] op_a, op_b, res_data;
  logic s_valid, s_ready, s_div, s_rvalid, s_rready, s_busy;
  logic [MS-1:0] s_a, s_b, s_res;
  bit   small_done = 0;
  int   checks = 0, errors = 0, cyc = 0, nres = 0;

  typedef struct packed {
    logic [M-1:0] data;
    logic         div;
    logic [31:0]  t0;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gfmd_unit #(.M(M), .G(G)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_div(op_div), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .busy(busy)
  );

  gfmd_unit #(.M(MS), .G(GS)) uut_small (
    .clk(clk), .rst_n(rst_n), .op_valid(s_valid), .op_ready(s_ready),
    .op_div(s_div), .op_a(s_a), .op_b(s_b), .res_valid(s_rvalid),
    .res_ready(s_rready), .res_data(s_res), .busy(s_busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: shift-and-add product, modular reduction by G
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M:0] acc = '0;
    for (int i = M-1; i >= 0; i--) begin
      acc = acc << 1;
      if (acc[M]) acc = acc ^ G;
      if (b[i]) acc = acc ^ {1'b0, a};
    end
    return acc[M-1:0];
  endfunction

  // Reference inverse: b^(2^M-2) as a product of repeated squares
  function automatic logic [M-1:0] ref_inv(input logic [M-1:0] b);
    logic [M-1:0] t = b;
    logic [M-1:0] r = M'(1);
    for (int i = 1; i < M; i++) begin
      t = ref_mul(t, t);
      r = ref_mul(r, t);
    end
    return r;
  endfunction

  task automatic send(input bit div, input logic [M-1:0] a, input logic [M-1:0] b);
    exp_t e;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_div = div; op_a = a; op_b = b;
    @(posedge clk);
    #1;
    e.data = div ? ref_mul(a, ref_inv(b)) : ref_mul(a, b);
    e.div  = div;
    e.t0   = cyc;
    sb.push_back(e);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Scoreboard monitor with varying back-pressure
  initial begin
    exp_t e;
    res_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6", "unexpected result", res_data, 0);
        end else begin
          e = sb.pop_front();
          if (e.div) begin
            check(res_data == e.data, "R1", "quotient", res_data, e.data);
            check(cyc - e.t0 == 2*M-1, "R3", "division latency", cyc - e.t0, 2*M-1);
          end else begin
            // R8: a correct product relies on the fixed addend
            check(res_data == e.data, "R2", "product", res_data, e.data);
            check(cyc - e.t0 == M, "R4", "multiplication latency", cyc - e.t0, M);
          end
          repeat (nres % 4) begin
            @(negedge clk);
            check(res_valid && res_data == e.data, "R5", "held result", res_data, e.data);
            check(!op_ready, "R5", "ready while holding", op_ready, 0);
          end
        end
        nres++;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!res_valid && op_ready, "R5", "release after accept",
              {res_valid, op_ready}, 2'b01);
      end
    end
  end

  // Small field instance: worked example
  initial begin
    int t0;
    s_valid = 1'b0; s_div = 1'b0; s_a = '0; s_b = '0; s_rready = 1'b1;
    wait (rst_n);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1; s_div = (k == 0); s_a = 4'b1101; s_b = 4'b0111;
      @(posedge clk);
      #1 t0 = cyc;
      @(negedge clk);
      s_valid = 1'b0;
      while (!s_rvalid) @(negedge clk);
      if (k == 0) begin
        check(s_res == 4'b1000, "R9", "small quotient", s_res, 4'b1000);
        check(cyc - t0 == 7, "R9", "small division cycles", cyc - t0, 7);
      end else begin
        check(s_res == 4'b0101, "R9", "small product", s_res, 4'b0101);
        check(cyc - t0 == 4, "R9", "small multiplication cycles", cyc - t0, 4);
      end
    end
    small_done = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [M-1:0] ra, rb;
    op_valid = 1'b0; op_div = 1'b0; op_a = '0; op_b = '0;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check(op_ready && !res_valid && !busy, "R7", "in reset",
          {op_ready, res_valid, busy}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready && !res_valid && !busy, "R7", "after reset",
          {op_ready, res_valid, busy}, 3'b100);

    send(1'b1, 8'h00, 8'h53);   // R1 zero dividend
    send(1'b1, 8'h53, 8'h01);   // R1 divisor one
    send(1'b1, 8'h53, 8'h53);   // R1 equal operands
    send(1'b1, 8'h01, 8'h53);   // R1 plain inverse
    send(1'b0, 8'h00, 8'hFF);   // R2 zero factor
    send(1'b0, 8'h01, 8'hC3);   // R2 unit factor
    send(1'b0, 8'hFF, 8'hFF);   // R2 full operands

    // R6: commands offered while a division runs must be ignored
    send(1'b1, 8'hB7, 8'h2D);
    repeat (2) @(negedge clk);
    op_valid = 1'b1; op_div = 1'b0; op_a = 8'hAA; op_b = 8'h55;
    repeat (4) begin
      @(negedge clk);
      check(busy && !op_ready, "R6", "busy during foreign command",
            {busy, op_ready}, 2'b10);
    end
    op_valid = 1'b0;

    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      ra = seed[23:16];
      rb = seed[15:8];
      if (i % 2 == 0 && rb == '0) rb = 8'h01;
      send(i % 2 == 0, ra, rb);
    end

    @(negedge clk);
    while (sb.size() != 0 || res_valid || !small_done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sb.size() == 0 && !res_valid, "R6", "no leftover result",
          {sb.size(), res_valid}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule